// File: doc/BRIEF.md
# Streaming Histogram Equalizer

This block remaps a raster-scanned grayscale stream through a cumulative-histogram transfer function, with no frame buffer. Each enabled cycle it accepts one pixel code with its column and row, and the programmed frame width and height. Pixels whose column is below the width and whose row is below the height are active. Each active pixel is counted into a histogram bin and replaced on the output by the transfer-function entry for its code.

When the row reaches the height, the frame's vertical blanking has begun. The block then sweeps every bin once, one bin per enabled cycle. It accumulates a running sum, writes that sum into the transfer-function memory and zeroes the bin. The next frame is therefore equalized with the statistics of the frame before it. The output carries the unnormalized cumulative count and leaves any scaling to the consumer.

Horizontal blanking inside a frame does not advance the sweep. Vertical blanking must give at least as many enabled cycles as there are bins.

Top module: `hist_eq_stream`

## Requirements
- R1: Every input taken on an enabled cycle reaches `valid_out`, `pix_out`, `x_out` and `y_out` after exactly 4 enabled clock edges, with the coordinates unchanged.
- R2: `valid_out` is 1 only for inputs with `x_in < width_in` and `y_in < height_in`. For every other input, `valid_out` and `pix_out` are 0.
- R3: For an active pixel of code p, `pix_out` equals the number of active pixels of the previous frame whose code was less than or equal to p.
- R4: The bin sweep runs only on enabled cycles with `y_in >= height_in`. It visits bins 0 to 255 in order, one per cycle, and then stays idle until the next frame. Rows inside the frame, including their horizontal blanking, do not advance it.
- R5: The sweep zeroes every bin, so each frame's transfer function reflects only that frame's active pixels.
- R6: Consecutive active pixels with the same code are each counted; no increment is lost to the read-modify-write latency. This includes runs of code 0 and code 255.
- R7: While `ce_in` is 0, no register or memory changes, the inputs are ignored, and the outputs hold their values.
- R8: Synchronous active-high `rst` clears the pipeline, the sweep index and the running sum. After reset `valid_out` and `pix_out` read 0, and a transfer-function entry never written by a sweep reads 0, so the first frame's output pixels are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_in | input | 1 | Clock enable for the whole block |
| pix_in | input | 8 | Incoming pixel code |
| x_in | input | 11 | Column of the incoming pixel |
| y_in | input | 9 | Row of the incoming pixel |
| width_in | input | 9 | Number of active columns |
| height_in | input | 9 | Number of active rows |
| pix_out | output | 19 | Equalized pixel: cumulative count |
| x_out | output | 11 | Column, delayed to match |
| y_out | output | 9 | Row, delayed to match |
| valid_out | output | 1 | Output pixel is active |

## Verification
A wrong bin count, whether lost on a run of equal codes or left over because a sweep did not clear it, stays invisible during the frame where it happens. It shows one frame later as a wrong cumulative value on every output pixel whose code is at or above the damaged bin. A sweep that steps during horizontal blanking breaks the transfer function within the same frame, on the next active pixel. A latency or stall fault shows on the very next enabled cycle as misaligned coordinates on `x_out` and `y_out`.

// File: rtl/hist_eq_pkg.sv
package hist_eq_pkg;

    localparam int PIX_W = 8;   // pixel code width, 2**PIX_W bins
    localparam int CNT_W = 19;  // bin count and cumulative sum width
    localparam int X_W   = 11;  // column width
    localparam int Y_W   = 9;   // row width
    localparam int DIM_W = 9;   // width / height input width

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_COUNT = 2'd1,
        OP_SWEEP = 2'd2
    } op_kind_e;

endpackage

// File: rtl/hist_eq_ram.sv
// Synchronous-read, write-first memory with per-entry written flags so that
// entries never written since reset read back as zero.
module hist_eq_ram #(
    parameter int AW = 8,
    parameter int DW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] live_d, live_q;
    logic [DW-1:0]    rd_d, rd_q;

    always_comb begin
        live_d = live_q;
        if (wr_en) begin
            live_d[wr_addr] = 1'b1;
        end
        if (wr_en && (wr_addr == rd_addr)) begin
            rd_d = wr_data;
        end else if (live_q[rd_addr]) begin
            rd_d = mem_q[rd_addr];
        end else begin
            rd_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            rd_q   <= '0;
        end else if (ce) begin
            live_q <= live_d;
            rd_q   <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && ce && wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = rd_q;

    // R6: a read colliding with a write returns the value being written
    assert_write_first_R6: assert property (@(posedge clk) disable iff (rst)
        (ce && wr_en && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/hist_eq_sweep.sv
// Bin sweep sequencer: walks every bin once per vertical blanking interval.
module hist_eq_sweep #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          blank,
    output logic          op_en,
    output logic [AW-1:0] op_idx,
    output logic          op_first
);
    localparam logic [AW-1:0] IDX_LAST = '1;

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          done;
    } sweep_t;

    sweep_t sw_d, sw_q;

    always_comb begin
        sw_d     = sw_q;
        op_en    = blank && !sw_q.done;
        op_idx   = sw_q.idx;
        op_first = (sw_q.idx == '0);
        if (!blank) begin
            sw_d.idx  = '0;
            sw_d.done = 1'b0;
        end else if (op_en) begin
            sw_d.idx  = sw_q.idx + AW'(1);
            sw_d.done = (sw_q.idx == IDX_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
        end else if (ce) begin
            sw_q <= sw_d;
        end
    end

    // R4: the sweep advances by one bin per enabled cycle while blanking lasts
    assert_sweep_steps_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && op_en && (op_idx != IDX_LAST)) |=> (!op_en || (op_idx == $past(op_idx) + AW'(1))));

    // R4: after the last bin the sweep stays idle
    assert_sweep_stops_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && op_en && (op_idx == IDX_LAST)) |=> !op_en);

endmodule

// File: rtl/hist_eq_stream.sv
module hist_eq_stream
    import hist_eq_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int CW = CNT_W,
    parameter int XW = X_W,
    parameter int YW = Y_W,
    parameter int DW = DIM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_in,
    input  logic [PW-1:0] pix_in,
    input  logic [XW-1:0] x_in,
    input  logic [YW-1:0] y_in,
    input  logic [DW-1:0] width_in,
    input  logic [DW-1:0] height_in,
    output logic [CW-1:0] pix_out,
    output logic [XW-1:0] x_out,
    output logic [YW-1:0] y_out,
    output logic          valid_out
);
    localparam int HX_W = (XW > DW) ? XW : DW;
    localparam int HY_W = (YW > DW) ? YW : DW;

    typedef struct packed {
        op_kind_e      op;
        logic          first;
        logic [PW-1:0] addr;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } stage_t;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] pix;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } out_t;

    typedef struct packed {
        stage_t        s1;
        stage_t        s2;
        out_t          s3;
        out_t          s4;
        logic [CW-1:0] cum;
    } state_t;

    state_t st_d, st_q;

    logic          in_active, in_blank;
    logic          op_en, op_first;
    logic [PW-1:0] op_idx;
    logic [CW-1:0] hist_rd, tf_rd;
    logic          hist_we, tf_we;
    logic [CW-1:0] hist_wd, cum_sum;

    always_comb begin
        in_active = (HX_W'(x_in) < HX_W'(width_in)) && (HY_W'(y_in) < HY_W'(height_in));
        in_blank  = (HY_W'(y_in) >= HY_W'(height_in));
    end

    hist_eq_sweep #(.AW(PW)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce_in),
        .blank    (in_blank),
        .op_en    (op_en),
        .op_idx   (op_idx),
        .op_first (op_first)
    );

    hist_eq_ram #(.AW(PW), .DW(CW)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce_in),
        .rd_addr (st_q.s1.addr),
        .rd_data (hist_rd),
        .wr_en   (hist_we),
        .wr_addr (st_q.s2.addr),
        .wr_data (hist_wd)
    );

    hist_eq_ram #(.AW(PW), .DW(CW)) u_xfer (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce_in),
        .rd_addr (st_q.s1.addr),
        .rd_data (tf_rd),
        .wr_en   (tf_we),
        .wr_addr (st_q.s2.addr),
        .wr_data (cum_sum)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: classify the input and pick the memory address
        if (in_active) begin
            st_d.s1.op   = OP_COUNT;
            st_d.s1.addr = pix_in;
        end else if (op_en) begin
            st_d.s1.op   = OP_SWEEP;
            st_d.s1.addr = op_idx;
        end else begin
            st_d.s1.op   = OP_IDLE;
            st_d.s1.addr = pix_in;
        end
        st_d.s1.first = op_first;
        st_d.s1.x     = x_in;
        st_d.s1.y     = y_in;

        // stage 2: memory read in flight
        st_d.s2 = st_q.s1;

        // stage 2 result: histogram update and sweep accumulation
        cum_sum = (st_q.s2.first ? '0 : st_q.cum) + hist_rd;
        hist_we = (st_q.s2.op != OP_IDLE);
        hist_wd = (st_q.s2.op == OP_COUNT) ? hist_rd + CW'(1) : '0;
        tf_we   = (st_q.s2.op == OP_SWEEP);
        if (st_q.s2.op == OP_SWEEP) begin
            st_d.cum = cum_sum;
        end

        st_d.s3.vld = (st_q.s2.op == OP_COUNT);
        st_d.s3.pix = (st_q.s2.op == OP_COUNT) ? tf_rd : '0;
        st_d.s3.x   = st_q.s2.x;
        st_d.s3.y   = st_q.s2.y;

        // stage 4: output register
        st_d.s4 = st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (ce_in) begin
            st_q <= st_d;
        end
    end

    assign pix_out   = st_q.s4.pix;
    assign x_out     = st_q.s4.x;
    assign y_out     = st_q.s4.y;
    assign valid_out = st_q.s4.vld;

    // R2: inactive output slots carry a zero pixel
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> (pix_out == '0));

    // R7: a disabled cycle leaves every output unchanged
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ce_in |=> ($stable(valid_out) && $stable(pix_out) && $stable(x_out) && $stable(y_out)));

    // R3: the running sum never wraps within a sweep
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        ((st_q.s2.op == OP_SWEEP) && !st_q.s2.first) |-> (cum_sum >= st_q.cum));

endmodule

// File: tb/hist_eq_stream_bench.sv
`timescale 1ns/1ps
module hist_eq_stream_bench;

    localparam int HBLANK = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_in = 1'b1;
    logic [7:0]  pix_in = '0;
    logic [10:0] x_in = '0;
    logic [8:0]  y_in = '0;
    logic [8:0]  width_in = 9'd8;
    logic [8:0]  height_in = 9'd4;
    logic [18:0] pix_out;
    logic [10:0] x_out;
    logic [8:0]  y_out;
    logic        valid_out;

    hist_eq_stream u_hist_eq_stream (
        .clk       (clk),
        .rst       (rst),
        .ce_in     (ce_in),
        .pix_in    (pix_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .width_in  (width_in),
        .height_in (height_in),
        .pix_out   (pix_out),
        .x_out     (x_out),
        .y_out     (y_out),
        .valid_out (valid_out)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int    due;
        bit    vld;
        int    pix;
        int    x;
        int    y;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   edge_cnt = 0;
    bit   finished = 0;
    int   hist_m [256];
    int   tf_m [256];

    always @(posedge clk) begin
        if (!rst && ce_in) edge_cnt <= edge_cnt + 1;
    end

    // monitor: R1 latency and alignment, compared when each item falls due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == edge_cnt) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (valid_out !== e.vld || int'(pix_out) != e.pix ||
                int'(x_out) != e.x || int'(y_out) != e.y) begin
                fails++;
                $display("FAIL %s: got vld=%0d pix=%0d x=%0d y=%0d, expected vld=%0d pix=%0d x=%0d y=%0d",
                         e.req, valid_out, pix_out, x_out, y_out, e.vld, e.pix, e.x, e.y);
            end
        end
    end

    task automatic push_item(input int x, input int y, input int p, input string req);
        exp_t e;
        bit act;
        act = (x < int'(width_in)) && (y < int'(height_in));
        e.due = edge_cnt + 4;
        e.vld = act;
        e.pix = act ? tf_m[p] : 0;
        e.x   = x;
        e.y   = y;
        e.req = act ? req : "R2";
        if (act) hist_m[p]++;
        q.push_back(e);
    endtask

    // drives one item; with stalls on, inserts disabled cycles carrying junk (R7)
    task automatic drive_item(input int x, input int y, input int p, input bit stall, input string req);
        while (stall && ($urandom % 4 == 0)) begin
            ce_in  = 1'b0;
            x_in   = '0;
            y_in   = '0;
            pix_in = 8'd200;
            @(negedge clk);
        end
        ce_in  = 1'b1;
        x_in   = 11'(x);
        y_in   = 9'(y);
        pix_in = 8'(p);
        push_item(x, y, p, req);
        @(negedge clk);
    endtask

    // end of frame: transfer function is the prefix sum of the counts (R3, R5)
    task automatic close_frame();
        int acc = 0;
        for (int b = 0; b < 256; b++) begin
            acc += hist_m[b];
            tf_m[b] = acc;
            hist_m[b] = 0;
        end
    endtask

    task automatic drive_frame(input int w, input int h, input int mode, input bit stall, input string req);
        int vrows;
        width_in  = 9'(w);
        height_in = 9'(h);
        vrows = 300 / (w + HBLANK) + 1;   // enough enabled blanking cycles for the R4 sweep
        for (int y = 0; y < h + vrows; y++) begin
            for (int x = 0; x < w + HBLANK; x++) begin
                int p;
                case (mode)
                    0: p = int'($urandom % 256);
                    1: p = ((x / 4) * 37 + y * 3) % 256;   // runs of four equal codes (R6)
                    2: p = 255;
                    default: p = 0;
                endcase
                drive_item(x, y, p, stall, req);
            end
        end
        close_frame();
    endtask

    initial begin
        for (int b = 0; b < 256; b++) begin
            hist_m[b] = 0;
            tf_m[b] = 0;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (valid_out !== 1'b0 || pix_out !== '0) begin
            fails++;
            $display("FAIL R8: got vld=%0d pix=%0d, expected vld=0 pix=0", valid_out, pix_out);
        end
        rst = 1'b0;
        drive_frame(8, 4, 0, 1'b0, "R8");   // first frame: unwritten entries read 0
        drive_frame(8, 4, 1, 1'b0, "R3");   // prefix sums of the random frame
        drive_frame(12, 5, 2, 1'b1, "R6");  // constant 255 under stalls
        drive_frame(8, 4, 3, 1'b1, "R7");   // constant 0, tf from the 255 frame only
        drive_frame(10, 3, 0, 1'b0, "R5");  // tf from the all-zero frame only
        drive_frame(5, 6, 1, 1'b0, "R3");
        for (int i = 0; i < 8; i++) drive_item(0, 400, 0, 1'b0, "R4");
        repeat (8) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d items never produced, expected 0", q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R1: watchdog expired, got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule